// File: doc/BRIEF.md
# Parallel-Port Block Transfer Engine

This engine moves a buffer of bytes between a host-side byte stream and a bridge chip's data register that sits behind a standard (non-EPP) parallel port. A single start pulse launches a transfer. The pulse carries a direction, a port mode and a byte count. The engine first emits a fixed prologue of data-port and control-port writes. It then moves one byte per control toggle, with a strobe phase bit that flips on every byte. It finishes with a fixed epilogue and a one-cycle done pulse.

Three port modes are handled. In nibble mode each byte is read as two halves from the upper status lines. In 5/3 mode five bits come from the status lines and three from the control-port read-back lines. In 8-bit mode the data port is read back directly. Read bytes leave on a valid/ready output stream. Write bytes arrive on a valid/ready input stream. Writes drive the data lines again only when a byte differs from the last byte driven, and they strobe the control port once per byte. Every port write is held for `HOLD` cycles before the next port action. This gives the bridge time to settle, and port inputs are sampled at the end of that hold.

Top module: `pp_block_xfer`

## Requirements
- R1: After reset the control port reads 0x04, the data port reads 0x00, and rd_valid_o, wr_ready_o, done_o and both port write strobes are low.
- R2: A start with a byte count of zero raises done_o in the cycle after the start and performs no port write.
- R3: Read prologues, with D = data write and C = control write: mode 0 (nibble) is D81 C01 C03 DC1. Mode 1 (5/3) is D91 C01 D10 C03 D51 C05 DD1. Mode 2 (8-bit) is D89 C01 C23 C21. Mode 3 behaves as mode 2.
- R4: Read byte strobes use a phase bit that is 1 for the first byte and flips after each byte. Mode 0 writes control 0x02+ph and then 0x04+ph. Mode 1 writes 0x04+ph. Mode 2 writes 0x24+ph.
- R5: Port inputs are sampled HOLD cycles after the strobe that precedes them. Byte reassembly by mode: mode 0 gives {second status[7:4], first status[7:4]}. Mode 1 gives {pp_ctl_i[3:1], pp_stat_i[7:3]}. Mode 2 gives pp_data_i.
- R6: Read epilogues are D00 C04 in modes 0 and 1, and C06 C04 in mode 2.
- R7: Write transfers in every mode start with DA1 C01 C03 C01 C05. Each byte is strobed with control 0x04+ph, where ph is 0 for the first byte and flips after each byte.
- R8: During a write, the data port is written only when the byte differs from the last byte written in this transfer. The first byte is always written, even when it equals the prologue value on the lines.
- R9: A write transfer ends with C07 C04.
- R10: While rd_valid_o is high and rd_ready_i is low, rd_data_o and pp_ctl_o hold their values and no port write occurs.
- R11: Each cycle writes at most one port register. Every port write is followed by at least HOLD cycles without another port write.
- R12: done_o is a single-cycle pulse. It comes HOLD cycles after the last epilogue write. A start pulse during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| dir_wr_i | input | 1 | 1 = write to bridge, 0 = read from bridge |
| mode_i | input | 2 | 0 nibble, 1 5/3, 2 and 3 8-bit |
| count_i | input | CNT_W | Number of bytes to move |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Read stream consumer ready |
| wr_data_i | input | 8 | Byte to write |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Engine takes a write byte |
| pp_data_o | output | 8 | Data port output lines |
| pp_data_we_o | output | 1 | Data port written this cycle |
| pp_ctl_o | output | 8 | Control port output lines |
| pp_ctl_we_o | output | 1 | Control port written this cycle |
| pp_data_i | input | 8 | Data port read-back |
| pp_stat_i | input | 8 | Status port lines |
| pp_ctl_i | input | 8 | Control port read-back |
| done_o | output | 1 | Transfer complete pulse |

## Verification
Reads are tried in each of the three modes. The bench model places each byte's bits on different port lines for each mode and fills the unused lines with inverted or fixed junk, so a wrong merge or a sample taken under the wrong strobe shows up as a corrupted byte. Read back-pressure is applied from a pseudo-random pattern in two of the modes, which separates a held strobe from one that advances early. Write buffers contain runs of equal bytes, a first byte equal to the prologue value and bursts with gaps in wr_valid_i, which together check the skip rule and the alternating phase. A zero count and a start pulse issued in the middle of a transfer check the two edge cases of the launch logic.

// File: rtl/pp_xfer_pkg.sv
// Shared definitions for the parallel-port block transfer engine.
// Assumes 8-bit port registers and at most eight script steps per sequence.
package pp_xfer_pkg;

    localparam logic [1:0] PM_NIB  = 2'd0;
    localparam logic [1:0] PM_53   = 2'd1;
    localparam logic [1:0] PM_BYTE = 2'd2;

    localparam logic [7:0] CTL_IDLE = 8'h04;

    // One scripted port action: which register, which value, end of script.
    typedef struct packed {
        logic       to_ctl;
        logic [7:0] val;
        logic       last;
    } pp_step_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PRO, S_STB, S_SAMPA, S_SAMPB, S_OUT,
        S_FETCH, S_WSTB, S_EPI, S_DONE
    } pp_state_t;

endpackage

// File: rtl/pp_script.sv
// Fixed prologue/epilogue step tables, indexed by mode, direction and step.
// Assumes the mode is already normalised to 0..2; pure combinational lookup.
module pp_script
    import pp_xfer_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       is_write,
    input  logic       epi,
    input  logic [2:0] idx,
    output pp_step_t   step
);

    function automatic pp_step_t mk(input logic c, input logic [7:0] v, input logic l);
        pp_step_t s;
        s.to_ctl = c;
        s.val    = v;
        s.last   = l;
        return s;
    endfunction

    // Select the scripted step for the current sequence position.
    always_comb begin
        step = mk(1'b1, CTL_IDLE, 1'b1);
        if (is_write && !epi) begin
            case (idx)
                3'd0:    step = mk(1'b0, 8'hA1, 1'b0);
                3'd1:    step = mk(1'b1, 8'h01, 1'b0);
                3'd2:    step = mk(1'b1, 8'h03, 1'b0);
                3'd3:    step = mk(1'b1, 8'h01, 1'b0);
                default: step = mk(1'b1, 8'h05, 1'b1);
            endcase
        end else if (is_write && epi) begin
            step = (idx == 3'd0) ? mk(1'b1, 8'h07, 1'b0) : mk(1'b1, CTL_IDLE, 1'b1);
        end else if (epi) begin
            if (mode == PM_BYTE)
                step = (idx == 3'd0) ? mk(1'b1, 8'h06, 1'b0) : mk(1'b1, CTL_IDLE, 1'b1);
            else
                step = (idx == 3'd0) ? mk(1'b0, 8'h00, 1'b0) : mk(1'b1, CTL_IDLE, 1'b1);
        end else begin
            case (mode)
                PM_NIB: begin
                    case (idx)
                        3'd0:    step = mk(1'b0, 8'h81, 1'b0);
                        3'd1:    step = mk(1'b1, 8'h01, 1'b0);
                        3'd2:    step = mk(1'b1, 8'h03, 1'b0);
                        default: step = mk(1'b0, 8'hC1, 1'b1);
                    endcase
                end
                PM_53: begin
                    case (idx)
                        3'd0:    step = mk(1'b0, 8'h91, 1'b0);
                        3'd1:    step = mk(1'b1, 8'h01, 1'b0);
                        3'd2:    step = mk(1'b0, 8'h10, 1'b0);
                        3'd3:    step = mk(1'b1, 8'h03, 1'b0);
                        3'd4:    step = mk(1'b0, 8'h51, 1'b0);
                        3'd5:    step = mk(1'b1, 8'h05, 1'b0);
                        default: step = mk(1'b0, 8'hD1, 1'b1);
                    endcase
                end
                default: begin
                    case (idx)
                        3'd0:    step = mk(1'b0, 8'h89, 1'b0);
                        3'd1:    step = mk(1'b1, 8'h01, 1'b0);
                        3'd2:    step = mk(1'b1, 8'h23, 1'b0);
                        default: step = mk(1'b1, 8'h21, 1'b1);
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/pp_merge.sv
// Rebuilds a read byte from the port lines sampled in the current mode.
// Assumes first_stat holds the status captured under the first nibble strobe.
module pp_merge
    import pp_xfer_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [7:0] first_stat,
    input  logic [7:0] stat,
    input  logic [7:0] ctl_rb,
    input  logic [7:0] data_rb,
    output logic [7:0] byte_o
);

    // Choose the bit-field merge that matches the port mode.
    always_comb begin
        case (mode)
            PM_NIB:  byte_o = {stat[7:4], first_stat[7:4]};
            PM_53:   byte_o = {ctl_rb[3:1], stat[7:3]};
            default: byte_o = data_rb;
        endcase
    end

endmodule

// File: rtl/pp_pacer.sv
// Hold timer: after each port write, reports unsettled for HOLD cycles.
// Assumes kick is only raised while settled is high.
module pp_pacer #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic settled
);

    localparam int CW = (HOLD < 1) ? 1 : $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    // Load the hold count on a port write, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (kick)
            cnt_q <= CW'(HOLD);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign settled = (cnt_q == '0);

endmodule

// File: rtl/pp_block_xfer.sv
// Block transfer engine for a bridge chip behind a non-EPP parallel port.
// Runs a scripted prologue, one byte per strobe with alternating phase,
// then a scripted epilogue. Assumes the port inputs are valid HOLD cycles
// after each control write. Writes skip data-port updates for repeated bytes.
module pp_block_xfer
    import pp_xfer_pkg::*;
#(
    parameter int HOLD  = 2,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_wr_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_valid_o,
    input  logic             rd_ready_i,
    input  logic [7:0]       wr_data_i,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    output logic [7:0]       pp_data_o,
    output logic             pp_data_we_o,
    output logic [7:0]       pp_ctl_o,
    output logic             pp_ctl_we_o,
    input  logic [7:0]       pp_data_i,
    input  logic [7:0]       pp_stat_i,
    input  logic [7:0]       pp_ctl_i,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pp_state_t        st_q, st_n;
    logic [1:0]       mode_q, mode_n;
    logic             wr_q, wr_n;
    logic [CNT_W-1:0] rem_q, rem_n;
    logic             ph_q, ph_n;
    logic [2:0]       idx_q, idx_n;
    logic [7:0]       first_q, first_n;
    logic [7:0]       rdd_q, rdd_n;
    logic [7:0]       last_q, last_n;
    logic             lok_q, lok_n;
    logic [7:0]       pd_q, pc_q;
    logic             pdwe_q, pcwe_q;
    logic             do_d, do_c;
    logic [7:0]       wval;
    logic             settled;
    logic             eng_busy;
    logic [7:0]       merged;
    pp_step_t         step;

    pp_script u_script (
        .mode     (mode_q),
        .is_write (wr_q),
        .epi      (st_q == S_EPI),
        .idx      (idx_q),
        .step     (step)
    );

    pp_merge u_merge (
        .mode       (mode_q),
        .first_stat (first_q),
        .stat       (pp_stat_i),
        .ctl_rb     (pp_ctl_i),
        .data_rb    (pp_data_i),
        .byte_o     (merged)
    );

    pp_pacer #(.HOLD(HOLD)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (do_d | do_c),
        .settled (settled)
    );

    // Next-state, port action and stream handshake decode.
    always_comb begin
        st_n       = st_q;
        mode_n     = mode_q;
        wr_n       = wr_q;
        rem_n      = rem_q;
        ph_n       = ph_q;
        idx_n      = idx_q;
        first_n    = first_q;
        rdd_n      = rdd_q;
        last_n     = last_q;
        lok_n      = lok_q;
        do_d       = 1'b0;
        do_c       = 1'b0;
        wval       = 8'h00;
        rd_valid_o = 1'b0;
        wr_ready_o = 1'b0;
        done_o     = 1'b0;
        case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    mode_n = (mode_i == 2'd3) ? PM_BYTE : mode_i;
                    wr_n   = dir_wr_i;
                    rem_n  = count_i;
                    idx_n  = 3'd0;
                    st_n   = (count_i == '0) ? S_DONE : S_PRO;
                end
            end
            S_PRO: begin
                if (settled) begin
                    do_c = step.to_ctl;
                    do_d = !step.to_ctl;
                    wval = step.val;
                    if (step.last) begin
                        idx_n = 3'd0;
                        ph_n  = !wr_q;
                        lok_n = 1'b0;
                        st_n  = wr_q ? S_FETCH : S_STB;
                    end else begin
                        idx_n = idx_q + 3'd1;
                    end
                end
            end
            S_STB: begin
                if (settled) begin
                    do_c = 1'b1;
                    case (mode_q)
                        PM_NIB:  wval = {7'b0000001, ph_q};
                        PM_53:   wval = {7'b0000010, ph_q};
                        default: wval = {7'b0010010, ph_q};
                    endcase
                    st_n = (mode_q == PM_NIB) ? S_SAMPA : S_SAMPB;
                end
            end
            S_SAMPA: begin
                if (settled) begin
                    first_n = pp_stat_i;
                    do_c    = 1'b1;
                    wval    = {7'b0000010, ph_q};
                    st_n    = S_SAMPB;
                end
            end
            S_SAMPB: begin
                if (settled) begin
                    rdd_n = merged;
                    st_n  = S_OUT;
                end
            end
            S_OUT: begin
                rd_valid_o = 1'b1;
                if (rd_ready_i) begin
                    ph_n  = !ph_q;
                    rem_n = rem_q - ONE;
                    idx_n = 3'd0;
                    st_n  = (rem_q == ONE) ? S_EPI : S_STB;
                end
            end
            S_FETCH: begin
                wr_ready_o = settled;
                if (settled && wr_valid_i) begin
                    if (!lok_q || (wr_data_i != last_q)) begin
                        do_d   = 1'b1;
                        wval   = wr_data_i;
                        last_n = wr_data_i;
                        lok_n  = 1'b1;
                    end
                    st_n = S_WSTB;
                end
            end
            S_WSTB: begin
                if (settled) begin
                    do_c  = 1'b1;
                    wval  = {7'b0000010, ph_q};
                    ph_n  = !ph_q;
                    rem_n = rem_q - ONE;
                    idx_n = 3'd0;
                    st_n  = (rem_q == ONE) ? S_EPI : S_FETCH;
                end
            end
            S_EPI: begin
                if (settled) begin
                    do_c = step.to_ctl;
                    do_d = !step.to_ctl;
                    wval = step.val;
                    if (step.last)
                        st_n = S_DONE;
                    else
                        idx_n = idx_q + 3'd1;
                end
            end
            S_DONE: begin
                if (settled) begin
                    done_o = 1'b1;
                    st_n   = S_IDLE;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    // Sequencer and transfer context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            mode_q  <= PM_NIB;
            wr_q    <= 1'b0;
            rem_q   <= '0;
            ph_q    <= 1'b0;
            idx_q   <= 3'd0;
            first_q <= 8'h00;
            rdd_q   <= 8'h00;
            last_q  <= 8'h00;
            lok_q   <= 1'b0;
        end else begin
            st_q    <= st_n;
            mode_q  <= mode_n;
            wr_q    <= wr_n;
            rem_q   <= rem_n;
            ph_q    <= ph_n;
            idx_q   <= idx_n;
            first_q <= first_n;
            rdd_q   <= rdd_n;
            last_q  <= last_n;
            lok_q   <= lok_n;
        end
    end

    // Port output registers and their one-cycle write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q   <= 8'h00;
            pc_q   <= CTL_IDLE;
            pdwe_q <= 1'b0;
            pcwe_q <= 1'b0;
        end else begin
            if (do_d) pd_q <= wval;
            if (do_c) pc_q <= wval;
            pdwe_q <= do_d;
            pcwe_q <= do_c;
        end
    end

    assign eng_busy     = (st_q != S_IDLE);
    assign rd_data_o    = rdd_q;
    assign pp_data_o    = pd_q;
    assign pp_data_we_o = pdwe_q;
    assign pp_ctl_o     = pc_q;
    assign pp_ctl_we_o  = pcwe_q;

endmodule

// File: rtl/pp_block_xfer_chk.sv
// Protocol checker for pp_block_xfer, attached by bind below.
// Assumes the engine's internal busy flag is exposed through the bind.
module pp_block_xfer_chk #(
    parameter int HOLD  = 2,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] count_i,
    input logic             busy,
    input logic [7:0]       rd_data_o,
    input logic             rd_valid_o,
    input logic             rd_ready_i,
    input logic             wr_ready_o,
    input logic             pp_data_we_o,
    input logic             pp_ctl_we_o,
    input logic [7:0]       pp_ctl_o,
    input logic             done_o
);

    // R2
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && count_i == '0) |=> (done_o && !pp_ctl_we_o && !pp_data_we_o));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=>
            (rd_valid_o && $stable(rd_data_o) && $stable(pp_ctl_o) && !pp_ctl_we_o && !pp_data_we_o));

    // R10
    stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid_o && wr_ready_o));

    // R11
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pp_ctl_we_o && pp_data_we_o));

    generate
        if (HOLD > 0) begin : g_spacing
            // R11
            spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pp_ctl_we_o || pp_data_we_o) |=> !(pp_ctl_we_o || pp_data_we_o));
        end
    endgenerate

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind pp_block_xfer pp_block_xfer_chk #(.HOLD(HOLD), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .count_i      (count_i),
    .busy         (eng_busy),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o),
    .rd_ready_i   (rd_ready_i),
    .wr_ready_o   (wr_ready_o),
    .pp_data_we_o (pp_data_we_o),
    .pp_ctl_we_o  (pp_ctl_we_o),
    .pp_ctl_o     (pp_ctl_o),
    .done_o       (done_o)
);

// File: tb/test_pp_block_xfer.sv
// Scoreboard bench: tasks queue the expected port writes, a negedge monitor
// pops and compares them, and models the bridge's port lines from a buffer.
module test_pp_block_xfer;

    localparam int HOLD  = 2;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             dir_wr_i = 1'b0;
    logic [1:0]       mode_i = 2'd0;
    logic [CNT_W-1:0] count_i = '0;
    logic [7:0]       rd_data_o;
    logic             rd_valid_o;
    logic             rd_ready_i = 1'b0;
    logic [7:0]       wr_data_i = 8'h00;
    logic             wr_valid_i = 1'b0;
    logic             wr_ready_o;
    logic [7:0]       pp_data_o;
    logic             pp_data_we_o;
    logic [7:0]       pp_ctl_o;
    logic             pp_ctl_we_o;
    logic [7:0]       pp_data_i;
    logic [7:0]       pp_stat_i;
    logic [7:0]       pp_ctl_i;
    logic             done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int         exp_ops[$];
    logic [7:0] mem [64];
    logic [1:0] mode_tb = 2'd0;
    int         out_idx = 0;
    int         in_idx = 0;
    int         xfer_n = 0;
    logic       src_active = 1'b0;
    logic       stall = 1'b0;
    logic       done_seen = 1'b0;
    logic       wr_hs_pend = 1'b0;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_rd = 8'h00;
    logic [7:0] prev_ctl = 8'h00;
    logic [7:0] lfsr = 8'h5B;
    int         since_we = 100;

    always #4 clk = ~clk;

    pp_block_xfer #(.HOLD(HOLD), .CNT_W(CNT_W)) i_pp_block_xfer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_wr_i(dir_wr_i),
        .mode_i(mode_i), .count_i(count_i), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .wr_data_i(wr_data_i),
        .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .pp_data_o(pp_data_o),
        .pp_data_we_o(pp_data_we_o), .pp_ctl_o(pp_ctl_o), .pp_ctl_we_o(pp_ctl_we_o),
        .pp_data_i(pp_data_i), .pp_stat_i(pp_stat_i), .pp_ctl_i(pp_ctl_i),
        .done_o(done_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bridge model: byte out_idx placed on mode-specific lines, junk elsewhere.
    always_comb begin
        logic [7:0] cur;
        cur = mem[out_idx % 64];
        case (mode_tb)
            2'd0: begin
                pp_stat_i = pp_ctl_o[2] ? {cur[7:4], ~cur[3:0]} : {cur[3:0], ~cur[7:4]};
                pp_ctl_i  = 8'h5A;
                pp_data_i = 8'hC3;
            end
            2'd1: begin
                pp_stat_i = {cur[4:0], 3'b101};
                pp_ctl_i  = {4'b1010, cur[7:5], 1'b1};
                pp_data_i = 8'h3C;
            end
            default: begin
                pp_stat_i = 8'h96;
                pp_ctl_i  = 8'h69;
                pp_data_i = cur;
            end
        endcase
    end

    // Monitor and stream driver, all at the falling edge.
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rst_n) begin
            // R10: a stalled output keeps data, strobe and port quiet
            if (prev_stall)
                chk(rd_valid_o && rd_data_o == prev_rd && pp_ctl_o == prev_ctl
                    && !pp_data_we_o && !pp_ctl_we_o, "R10 stall hold",
                    {rd_data_o, pp_ctl_o}, {prev_rd, prev_ctl});
            // R11 / R3..R9: port write order and spacing
            if (pp_data_we_o || pp_ctl_we_o) begin
                chk(since_we >= HOLD, "R11 spacing", since_we, HOLD);
                if (exp_ops.size() == 0) begin
                    chk(1'b0, "R2/R12 unexpected port write", {pp_ctl_we_o, pp_ctl_we_o ? pp_ctl_o : pp_data_o}, 0);
                end else begin
                    int e;
                    e = exp_ops.pop_front();
                    chk({23'd0, pp_ctl_we_o, pp_ctl_we_o ? pp_ctl_o : pp_data_o} == e,
                        "R3-R9 port op", {pp_ctl_we_o, pp_ctl_we_o ? pp_ctl_o : pp_data_o}, e);
                end
                since_we = 0;
            end else begin
                since_we++;
            end
            // R12: done only after every expected op
            if (done_o) begin
                done_seen = 1'b1;
                chk(exp_ops.size() == 0, "R12 done after epilogue", exp_ops.size(), 0);
            end
            // read stream
            rd_ready_i = stall ? lfsr[1] : 1'b1;
            if (rd_valid_o && rd_ready_i) begin
                chk(rd_data_o == mem[out_idx % 64], "R5 read byte", rd_data_o, mem[out_idx % 64]);
                out_idx++;
            end
            prev_stall = rd_valid_o && !rd_ready_i;
            prev_rd    = rd_data_o;
            prev_ctl   = pp_ctl_o;
            // write stream
            if (wr_hs_pend) in_idx++;
            if (src_active && in_idx < xfer_n) begin
                wr_valid_i = stall ? lfsr[2] : 1'b1;
                wr_data_i  = mem[in_idx % 64];
            end else begin
                wr_valid_i = 1'b0;
            end
            wr_hs_pend = wr_valid_i && wr_ready_o;
        end
    end

    task automatic op(input logic c, input logic [7:0] v);
        exp_ops.push_back({23'd0, c, v});
    endtask

    task automatic build_read(input logic [1:0] m, input int n);
        if (m == 2'd0) begin
            op(0, 8'h81); op(1, 8'h01); op(1, 8'h03); op(0, 8'hC1);
        end else if (m == 2'd1) begin
            op(0, 8'h91); op(1, 8'h01); op(0, 8'h10); op(1, 8'h03);
            op(0, 8'h51); op(1, 8'h05); op(0, 8'hD1);
        end else begin
            op(0, 8'h89); op(1, 8'h01); op(1, 8'h23); op(1, 8'h21);
        end
        for (int k = 0; k < n; k++) begin
            logic [7:0] ph;
            ph = (k % 2 == 0) ? 8'd1 : 8'd0;
            if (m == 2'd0) begin
                op(1, 8'h02 + ph); op(1, 8'h04 + ph);
            end else if (m == 2'd1) begin
                op(1, 8'h04 + ph);
            end else begin
                op(1, 8'h24 + ph);
            end
        end
        if (m == 2'd0 || m == 2'd1) begin
            op(0, 8'h00); op(1, 8'h04);
        end else begin
            op(1, 8'h06); op(1, 8'h04);
        end
    endtask

    task automatic build_write(input int n);
        int last;
        op(0, 8'hA1); op(1, 8'h01); op(1, 8'h03); op(1, 8'h01); op(1, 8'h05);
        last = -1;
        for (int k = 0; k < n; k++) begin
            if (int'(mem[k]) != last) begin
                op(0, mem[k]);
                last = int'(mem[k]);
            end
            op(1, (k % 2 == 0) ? 8'h04 : 8'h05);
        end
        op(1, 8'h07); op(1, 8'h04);
    endtask

    task automatic run(input logic wr, input logic [1:0] m, input int n,
                       input logic st, input logic poke, input string tag);
        if (wr) build_write(n); else build_read(m, n);
        @(negedge clk);
        mode_tb = (m == 2'd3) ? 2'd2 : m;
        out_idx = 0; in_idx = 0; xfer_n = n; stall = st;
        src_active = wr; done_seen = 1'b0;
        start_i = 1'b1; dir_wr_i = wr; mode_i = m; count_i = CNT_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (15) @(negedge clk);
            // R12: a start mid-transfer must not disturb the sequence
            start_i = 1'b1; dir_wr_i = ~wr; mode_i = 2'd0; count_i = CNT_W'(1);
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 5000 && !done_seen; i++) @(negedge clk);
        chk(done_seen, {tag, " done"}, done_seen, 1);
        chk(exp_ops.size() == 0, {tag, " all ops seen"}, exp_ops.size(), 0);
        if (wr) chk(in_idx == n, {tag, " bytes taken"}, in_idx, n);
        else    chk(out_idx == n, {tag, " bytes delivered"}, out_idx, n);
        src_active = 1'b0;
        exp_ops.delete();
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pp_ctl_o == 8'h04, "R1 ctl reset", pp_ctl_o, 8'h04);
        chk(pp_data_o == 8'h00, "R1 data reset", pp_data_o, 8'h00);
        chk(!rd_valid_o && !wr_ready_o && !done_o && !pp_ctl_we_o && !pp_data_we_o,
            "R1 flags reset", {rd_valid_o, wr_ready_o, done_o}, 0);

        // R2 zero count
        start_i = 1'b1; count_i = '0; dir_wr_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o, "R2 zero count done", done_o, 1);
        @(negedge clk);
        chk(!done_o, "R12 done single pulse", done_o, 0);
        repeat (4) @(negedge clk);

        // R3 R4 R5 R6 reads in each mode
        for (int k = 0; k < 64; k++) mem[k] = 8'((k * 37) ^ 8'hA5);
        run(1'b0, 2'd0, 6, 1'b0, 1'b0, "R4 nibble read");
        for (int k = 0; k < 64; k++) mem[k] = 8'((k * 91) + 8'h1E);
        run(1'b0, 2'd1, 5, 1'b1, 1'b0, "R5 5/3 read stalled");
        for (int k = 0; k < 64; k++) mem[k] = 8'((k * 53) ^ 8'h3C);
        run(1'b0, 2'd2, 7, 1'b1, 1'b1, "R6 8-bit read with busy start");
        run(1'b0, 2'd3, 3, 1'b0, 1'b0, "R3 mode 3 read");

        // R7 R8 R9 writes with repeats
        mem[0] = 8'hA1; mem[1] = 8'h3C; mem[2] = 8'h3C; mem[3] = 8'h3C;
        mem[4] = 8'h5A; mem[5] = 8'h5A; mem[6] = 8'h00;
        run(1'b1, 2'd0, 7, 1'b0, 1'b0, "R8 write repeats");
        for (int k = 0; k < 64; k++) mem[k] = (k % 3 == 0) ? 8'h77 : 8'((k / 2) * 8'h11);
        run(1'b1, 2'd2, 12, 1'b1, 1'b0, "R7 write gapped");
        for (int k = 0; k < 4; k++) mem[k] = 8'hEE;
        run(1'b1, 2'd1, 4, 1'b0, 1'b1, "R9 write constant with busy start");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule